// File: doc/BRIEF.md
# Event Counter Unit with Overflow Interrupt

This block is a register-mapped bank of event counters. Each counter is 64 bits wide and picks one of 256 event lines coming from a traffic-handling agent. Code zero is special: it counts every clock cycle and ignores its event line. Software programs the counters through a simple register port. It sets a master run bit and per-counter enables, chooses an event code for each counter, and can preload or read any counter as a full 64-bit word.

When a counter rolls over from all ones to zero, it latches a bit in an overflow status word. A status bit that is not masked drives a level interrupt. Software reads the status and clears bits by writing ones to a separate clear register. A configuration bit drives a power-management inhibit output, which software sets before it starts counting. A read-only version word identifies the block.

Top module: `evctr_unit`

## Requirements
- R1: After reset, every counter, the master run bit, the per-counter enables, the event selects, the status word, the configuration bit and the interrupt are 0, and the mask register (0x1C70) reads 0xFF.
- R2: While bit 0 of the control register (0x1C00) is 0, no counter changes except through a software write.
- R3: Counter n advances only while bit n of the enable register (0x1C04) is 1.
- R4: Counter n takes its 8-bit event code from byte (n mod 4) of the select register at 0x1C80 (counters 0-3) or 0x1C84 (counters 4-7), at bit shift 8·(n mod 4). It advances by one on each clock where the master bit, its enable bit and event line `evt_in[code]` are all 1.
- R5: Event code 0x00 advances the counter on every enabled clock, whatever the event lines hold.
- R6: Counter n is read and written as one 64-bit word at 0x1D00 + 8·n. A write in the same cycle as an increment wins, and that increment is lost.
- R7: When a counter steps from all ones to zero, its bit in the status register (0x1C78) reads 1 from the same clock edge on.
- R8: Writing the clear register (0x1C7C) clears every status bit written as 1 and leaves bits written as 0 unchanged. A rollover in the same cycle keeps its bit set.
- R9: A mask bit of 1 hides that counter's status from the interrupt. `irq` is 1 exactly when some status bit is 1 and its mask bit is 0, and it follows a status or mask change on the same edge.
- R10: Bit 9 of the configuration register (0x0534) is stored, read back and driven on `pm_inhibit`. All other bits of that register read 0.
- R11: The version register (0x1CF0) always reads the `VERSION` parameter, and writes to it are ignored.
- R12: A read issued with `reg_rd` returns its data on `rd_data` with `rd_valid` high one clock later. Unused bits of narrower registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Byte address of the register |
| reg_wdata | input | 64 | Write data; 32-bit registers use the low bits |
| rd_data | output | 64 | Registered read data |
| rd_valid | output | 1 | High for one clock when rd_data holds a read result |
| evt_in | input | 256 | Event lines, one per event code |
| irq | output | 1 | Level interrupt for unmasked overflow |
| pm_inhibit | output | 1 | Power-management inhibit from the configuration bit |

## Verification
The assertions take for granted that `reg_wr` and `reg_rd` are never high together. They also assume that a read and a counter update never meet: a counter is read back only once the master run bit is clear, so the value returned is steady. The stimulus follows both rules. It issues accesses one per clock from tasks, holds the event lines constant while a count window is open, and opens and closes each window with writes to the control register, so that the expected counts follow from the number of clocks alone. Overflow is reached by preloading a counter just below all ones rather than by counting through the full range.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  localparam int ADDR_W = 16;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CTRL = 16'h1C00;
  localparam addr_t A_EN   = 16'h1C04;
  localparam addr_t A_MASK = 16'h1C70;
  localparam addr_t A_STAT = 16'h1C78;
  localparam addr_t A_CLR  = 16'h1C7C;
  localparam addr_t A_SEL  = 16'h1C80;
  localparam addr_t A_VER  = 16'h1CF0;
  localparam addr_t A_CNT  = 16'h1D00;
  localparam addr_t A_CFG  = 16'h0534;
  localparam int    PM_BIT = 9;
endpackage

// File: rtl/evctr_lane.sv
module evctr_lane #(
  parameter int CNT_W = 64,
  parameter int EVT_W = 8,
  localparam int N_EVT = 1 << EVT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [EVT_W-1:0] code,
  input  logic [N_EVT-1:0] evt,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic hit, step;

  always_comb begin
    hit  = (code == '0) ? 1'b1 : evt[code];
    step = run && hit;
    wrap = step && !wr && (&cnt);
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wr)   cnt <= wdata;
    else if (step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/evctr_ovf.sv
module evctr_ovf #(
  parameter int N_CNT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CNT-1:0] wrap,
  input  logic             clr_wr,
  input  logic             mask_wr,
  input  logic [N_CNT-1:0] bits,
  output logic [N_CNT-1:0] status,
  output logic [N_CNT-1:0] mask,
  output logic             irq
);
  logic [N_CNT-1:0] st_n, mask_n;

  always_comb begin
    st_n   = (status & ~(clr_wr ? bits : '0)) | wrap;
    mask_n = mask_wr ? bits : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '1;
      irq    <= 1'b0;
    end else begin
      status <= st_n;
      mask   <= mask_n;
      irq    <= |(st_n & ~mask_n);
    end
  end
endmodule

// File: rtl/evctr_unit.sv
module evctr_unit
  import evctr_pkg::*;
#(
  parameter int          N_CNT   = 8,
  parameter int          CNT_W   = 64,
  parameter int          EVT_W   = 8,
  parameter int          DATA_W  = 64,
  parameter logic [31:0] VERSION = 32'h0001_0002,
  localparam int         N_EVT   = 1 << EVT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [N_EVT-1:0]  evt_in,
  output logic              irq,
  output logic              pm_inhibit
);
  localparam int PER_SEL = 32 / EVT_W;
  localparam int N_SEL   = (N_CNT + PER_SEL - 1) / PER_SEL;

  logic             ctrl_en_q;
  logic [N_CNT-1:0] en_q;
  logic [31:0]      sel_q [N_SEL];
  logic             pm_q;

  logic [N_CNT-1:0]       cnt_wr, wrap, status, mask;
  logic [N_CNT*CNT_W-1:0] cnt_flat;
  logic [DATA_W-1:0]      rd_mux;
  logic                   clr_wr, mask_wr;

  assign clr_wr     = reg_wr && (reg_addr == A_CLR);
  assign mask_wr    = reg_wr && (reg_addr == A_MASK);
  assign pm_inhibit = pm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en_q <= 1'b0;
      en_q      <= '0;
      pm_q      <= 1'b0;
      for (int s = 0; s < N_SEL; s++) sel_q[s] <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) ctrl_en_q <= reg_wdata[0];
      if (reg_addr == A_EN)   en_q      <= reg_wdata[N_CNT-1:0];
      if (reg_addr == A_CFG)  pm_q      <= reg_wdata[PM_BIT];
      for (int s = 0; s < N_SEL; s++)
        if (reg_addr == A_SEL + ADDR_W'(4 * s)) sel_q[s] <= reg_wdata[31:0];
    end
  end

  for (genvar g = 0; g < N_CNT; g++) begin : g_lane
    logic [CNT_W-1:0] cnt;
    assign cnt_wr[g] = reg_wr && (reg_addr == A_CNT + ADDR_W'(8 * g));
    evctr_lane #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .run   (ctrl_en_q && en_q[g]),
      .code  (sel_q[g / PER_SEL][EVT_W*(g % PER_SEL) +: EVT_W]),
      .evt   (evt_in),
      .wr    (cnt_wr[g]),
      .wdata (reg_wdata[CNT_W-1:0]),
      .cnt   (cnt),
      .wrap  (wrap[g])
    );
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt;
  end

  evctr_ovf #(.N_CNT(N_CNT)) u_ovf (
    .clk     (clk),
    .rst     (rst),
    .wrap    (wrap),
    .clr_wr  (clr_wr),
    .mask_wr (mask_wr),
    .bits    (reg_wdata[N_CNT-1:0]),
    .status  (status),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL:  rd_mux[0] = ctrl_en_q;
      A_EN:    rd_mux = DATA_W'(en_q);
      A_MASK:  rd_mux = DATA_W'(mask);
      A_STAT:  rd_mux = DATA_W'(status);
      A_VER:   rd_mux = DATA_W'(VERSION);
      A_CFG:   rd_mux[PM_BIT] = pm_q;
      default: rd_mux = '0;
    endcase
    for (int s = 0; s < N_SEL; s++)
      if (reg_addr == A_SEL + ADDR_W'(4 * s)) rd_mux = DATA_W'(sel_q[s]);
    for (int c = 0; c < N_CNT; c++)
      if (reg_addr == A_CNT + ADDR_W'(8 * c)) rd_mux = DATA_W'(cnt_flat[c*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/evctr_chk.sv
module evctr_chk
  import evctr_pkg::*;
#(
  parameter int          N_CNT   = 8,
  parameter int          CNT_W   = 64,
  parameter int          DATA_W  = 64,
  parameter logic [31:0] VERSION = 32'h0001_0002
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   reg_wr,
  input logic                   reg_rd,
  input logic [15:0]            reg_addr,
  input logic [DATA_W-1:0]      reg_wdata,
  input logic [DATA_W-1:0]      rd_data,
  input logic                   rd_valid,
  input logic                   glob_en,
  input logic [N_CNT-1:0]       cnt_wr,
  input logic [N_CNT*CNT_W-1:0] cnt_flat,
  input logic [N_CNT-1:0]       wrap,
  input logic [N_CNT-1:0]       status,
  input logic [N_CNT-1:0]       mask,
  input logic                   irq
);
  a_r2_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
    (!glob_en && cnt_wr == '0) |=> $stable(cnt_flat));

  a_r7_wrap_sets_status: assert property (@(posedge clk) disable iff (rst)
    (|wrap) |=> ((status & $past(wrap)) == $past(wrap)));

  a_r8_clear_drops_bits: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_CLR && wrap == '0) |=> ((status & $past(reg_wdata[N_CNT-1:0])) == '0));

  a_r9_irq_needs_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|(status & ~mask)));

  a_r9_source_raises_irq: assert property (@(posedge clk) disable iff (rst)
    (|(status & ~mask)) |-> irq);

  a_r12_read_returns: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> rd_valid);

  a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !rd_valid);

  a_r11_version_const: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_VER) |=> (rd_data == DATA_W'(VERSION)));
endmodule

bind evctr_unit evctr_chk #(
  .N_CNT(N_CNT), .CNT_W(CNT_W), .DATA_W(DATA_W), .VERSION(VERSION)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .glob_en   (ctrl_en_q),
  .cnt_wr    (cnt_wr),
  .cnt_flat  (cnt_flat),
  .wrap      (wrap),
  .status    (status),
  .mask      (mask),
  .irq       (irq)
);

// File: tb/tb_evctr_unit.sv
module tb_evctr_unit;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] VER        = 32'h0001_0002;

  localparam logic [15:0] CTRL = 16'h1C00, EN = 16'h1C04, MASK = 16'h1C70,
                          STAT = 16'h1C78, CLR = 16'h1C7C, SEL0 = 16'h1C80,
                          SEL1 = 16'h1C84, VREG = 16'h1CF0, CNT0 = 16'h1D00,
                          CFG = 16'h0534;

  logic        clk = 0, rst = 1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] rd_data;
  logic        rd_valid, irq, pm_inhibit;
  logic [255:0] evt_in = '0;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] q_exp[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  evctr_unit #(.VERSION(VER)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .evt_in(evt_in), .irq(irq), .pm_inhibit(pm_inhibit)
  );

  function automatic logic [15:0] cnt_a(int n);
    return CNT0 + 16'(8 * n);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [63:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, logic [63:0] exp, string tag);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (q_exp.size() == 0) chk("R12 unexpected rd_valid", 64'd1, 64'd0);
      else chk(q_tag.pop_front(), rd_data, q_exp.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", 64'(irq), 0);
    chk("R1 pm_inhibit", 64'(pm_inhibit), 0);
    rd(CTRL, 0, "R1 ctrl");
    rd(EN, 0, "R1 enables");
    rd(MASK, 64'hFF, "R1 mask");
    rd(STAT, 0, "R1 status");
    rd(SEL0, 0, "R1 select");
    rd(cnt_a(7), 0, "R1 counter7");
    rd(CFG, 0, "R1 cfg");
    idle(1);
    chk("R12 rd_valid idle", 64'(rd_valid), 0);

    // R6 preload, R2 master off, R5 cycle code, R3 per-counter enable
    wr(cnt_a(0), 64'd100);
    rd(cnt_a(0), 64'd100, "R6 counter write/read");
    wr(EN, 64'h01);
    idle(5);
    rd(cnt_a(0), 64'd100, "R2 no count while master off");
    wr(CTRL, 1);
    wr(CTRL, 0);
    rd(cnt_a(0), 64'd101, "R5 code 0 counts cycles");
    rd(cnt_a(1), 64'd0, "R3 disabled counter holds");

    // R4 select byte placement
    evt_in[8'h62] = 1; evt_in[8'h61] = 1;
    wr(SEL1, 64'h62E1);
    wr(EN, 64'h30);
    wr(CTRL, 1);
    idle(2);
    wr(CTRL, 0);
    rd(SEL1, 64'h62E1, "R4 select readback");
    rd(cnt_a(5), 64'd3, "R4 counter5 byte1 event");
    rd(cnt_a(4), 64'd0, "R4 counter4 idle event");
    rd(cnt_a(6), 64'd0, "R3 counter6 not enabled");

    // R6 write beats increment
    wr(EN, 64'h01);
    wr(CTRL, 1);
    wr(cnt_a(0), 64'd50);
    wr(CTRL, 0);
    rd(cnt_a(0), 64'd51, "R6 write wins over increment");

    // R7 / R9 overflow
    wr(MASK, 64'hFE);
    wr(cnt_a(0), 64'hFFFF_FFFF_FFFF_FFFE);
    wr(CTRL, 1);
    wr(CTRL, 0);
    chk("R9 no irq before wrap", 64'(irq), 0);
    rd(STAT, 0, "R7 no status before wrap");
    wr(CTRL, 1);
    wr(CTRL, 0);
    chk("R9 irq on wrap", 64'(irq), 1);
    rd(STAT, 64'h01, "R7 status after wrap");
    rd(cnt_a(0), 0, "R7 counter wrapped to zero");
    wr(MASK, 64'hFF);
    chk("R9 masked irq low", 64'(irq), 0);
    rd(STAT, 64'h01, "R9 mask keeps status");
    wr(MASK, 64'hFE);
    chk("R9 unmask irq high", 64'(irq), 1);

    // R8 write-one-to-clear
    wr(CLR, 0);
    rd(STAT, 64'h01, "R8 zero write no effect");
    wr(CLR, 64'h01);
    rd(STAT, 0, "R8 one clears");
    chk("R8 irq after clear", 64'(irq), 0);

    // R10 power-management bit
    wr(CFG, 64'h200);
    chk("R10 pm_inhibit set", 64'(pm_inhibit), 1);
    rd(CFG, 64'h200, "R10 cfg readback");
    wr(CFG, 64'hFFFF_FDFF);
    chk("R10 pm_inhibit clear", 64'(pm_inhibit), 0);
    rd(CFG, 0, "R10 other bits read 0");

    // R11 version
    rd(VREG, 64'(VER), "R11 version");
    wr(VREG, 0);
    rd(VREG, 64'(VER), "R11 version after write");

    idle(3);
    chk("R12 all reads returned", 64'(q_exp.size()), 0);
    finish_run();
  end
endmodule